// File: doc/BRIEF.md
# LIN Response Engine with Checksum

This block runs the response half of a LIN frame once the header has been handled elsewhere. A transmit command makes it send a set number of data bytes from a host byte queue to the byte serializer, followed by the checksum byte. A receive command makes it take a set number of bytes from the byte deserializer, pass each data byte out, and check the closing checksum byte. It then returns to its idle command state without any further input.

The checksum mode is chosen for each frame when the command starts. An enhanced sum seeds the accumulator with the protected identifier. A classic sum starts from zero. A protocol-version input selects between them, but identifiers 0x3C to 0x3F always get the classic sum. A frame timer runs through the whole response. Bit errors from the serializer, framing errors from the deserializer, checksum mismatches and timeouts each set a sticky flag, stop the response and release the bus. A header may arrive while a response is running. Its identifier is stored for the next frame, and the running frame and the existing flags are left as they are.

Top module: `lin_resp_engine`

## Requirements
- R1: After a transmit command (code 01), `ser_tx_valid` rises in the next cycle. The data bytes go out in queue order, one for each accepted handshake (`ser_tx_valid` and `ser_tx_ready`), with one `tx_data_pop` for each. The checksum byte follows, then `flag_tx_ok` is set and `cmd_state` returns to 00.
- R2: The transmit length comes from `tx_len` and the receive length from `rx_len`. Both are sampled when the command starts, and any value above 8 means 8 data bytes.
- R3: When `ver_enh` is 1 and the stored identifier bits [5:0] are below 0x3C, the checksum covers the stored protected identifier byte plus all data bytes.
- R4: When `ver_enh` is 0, or the identifier bits [5:0] are 0x3C to 0x3F, the checksum covers the data bytes only.
- R5: The sum is 8-bit addition with the carry added back in. The transmitted checksum is the bitwise inverse of that sum.
- R6: On a receive command (code 10), each incoming data byte appears on `rx_data` with `rx_data_valid`. After the last data byte, the next byte is the checksum. If the sum including it is 0xFF, `flag_rx_ok` is set. Otherwise error bit [2] (checksum) is set. Either way `cmd_state` returns to 00.
- R7: A receive command in the same cycle as `des_valid` counts that byte as the first response byte.
- R8: A serializer bit error during transmit sets error bit [0], and a framing error on a received byte sets error bit [1]. Either one returns `cmd_state` to 00 and drops `ser_tx_valid` in the next cycle.
- R9: If a response is still running (n+1)·`SLOT_CYC` cycles after its command, where n is the clamped length, error bit [3] (timeout) is set and `cmd_state` returns to 00.
- R10: `hdr_valid` loads `hdr_pid` into `cur_pid` at any time, including during a response, without changing the running frame's checksum. All flags stay set until a `flag_clr` pulse.
- R11: After reset `cmd_state` is 00 and all flags are 0. Command 00 aborts any response to 00 in the next cycle and sets no flag. A transmit or receive command given while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 2 | 00 abort/idle, 01 transmit, 10 receive |
| ver_enh | input | 1 | 1 selects enhanced checksum (newer protocol) |
| rx_len | input | 4 | Receive data length |
| tx_len | input | 4 | Transmit data length |
| hdr_valid | input | 1 | Header identifier strobe |
| hdr_pid | input | 8 | Protected identifier of the header |
| tx_data | input | 8 | Head of host transmit queue |
| tx_data_pop | output | 1 | Consume queue head |
| ser_tx_valid | output | 1 | Byte offered to serializer; low means bus recessive |
| ser_tx_data | output | 8 | Byte to serializer |
| ser_tx_ready | input | 1 | Serializer takes byte |
| ser_bit_err | input | 1 | Serializer readback mismatch |
| des_valid | input | 1 | Deserializer byte complete |
| des_data | input | 8 | Received byte |
| des_ferr | input | 1 | Framing error on that byte |
| rx_data_valid | output | 1 | Received data byte strobe |
| rx_data | output | 8 | Received data byte |
| flag_clr | input | 1 | Clear all flags |
| cmd_state | output | 2 | Current command, 00 when idle |
| cur_pid | output | 8 | Stored protected identifier |
| flag_tx_ok | output | 1 | Transmit response completed |
| flag_rx_ok | output | 1 | Receive response completed with good checksum |
| err_flags | output | 4 | [0] bit, [1] framing, [2] checksum, [3] timeout |

## Verification
The bench goes after identifier 0x3C with the enhanced mode selected. A design that checks only the version bit would seed the identifier there and send the wrong checksum byte. Data bytes chosen to carry out of bit 7 catch a sum that drops its carry. A length of 12 catches a missing clamp, which would pull extra queue bytes or treat the ninth received byte as data. A receive command that lands on the first byte's completion catches a design that would lose that byte and then time out. A header arriving mid-response, with an old error flag still set, exposes a design that reseeds the running sum or clears flags on a new header.

// File: rtl/lin_resp_pkg.sv
package lin_resp_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'b00,
        CMD_TX   = 2'b01,
        CMD_RX   = 2'b10
    } cmd_e;

    localparam int          MAX_DATA    = 8;
    localparam logic [5:0]  CLASSIC_LO  = 6'h3C;

    localparam int E_BIT  = 0;
    localparam int E_FRM  = 1;
    localparam int E_CKS  = 2;
    localparam int E_TMO  = 3;

    typedef struct packed {
        cmd_e       cmd;
        logic [3:0] nbytes;
        logic [3:0] idx;
    } ctx_t;

    function automatic logic [7:0] cks_add(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[7:0] + {7'd0, s[8]};
    endfunction

    function automatic logic [3:0] clamp_len(input logic [3:0] len);
        return (len > 4'(MAX_DATA)) ? 4'(MAX_DATA) : len;
    endfunction

    function automatic logic use_enhanced(input logic ver, input logic [5:0] id);
        return ver && (id < CLASSIC_LO);
    endfunction

endpackage

// File: rtl/lin_cks_acc.sv
module lin_cks_acc
    import lin_resp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       init,
    input  logic [7:0] seed,
    input  logic       add_en,
    input  logic [7:0] add_byte,
    output logic [7:0] sum
);
    logic [7:0] base;

    assign base = init ? seed : sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            sum <= 8'h00;
        end else if (init || add_en) begin
            sum <= add_en ? cks_add(base, add_byte) : base;
        end
    end
endmodule

// File: rtl/lin_frame_timer.sv
module lin_frame_timer #(
    parameter int SLOT_CYC = 160
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       run,
    input  logic [3:0] nbytes,
    output logic       expire
);
    localparam int TW = $clog2(9 * SLOT_CYC + 2) + 1;

    logic [TW-1:0] cnt;
    logic [TW-1:0] limit;

    assign limit  = (TW'(nbytes) + TW'(1)) * TW'(SLOT_CYC);
    assign expire = run && (cnt == limit - TW'(1));

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + TW'(1);
        end
    end
endmodule

// File: rtl/lin_resp_engine.sv
module lin_resp_engine
    import lin_resp_pkg::*;
#(
    parameter int SLOT_CYC = 160
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_code,
    input  logic       ver_enh,
    input  logic [3:0] rx_len,
    input  logic [3:0] tx_len,
    input  logic       hdr_valid,
    input  logic [7:0] hdr_pid,
    input  logic [7:0] tx_data,
    output logic       tx_data_pop,
    output logic       ser_tx_valid,
    output logic [7:0] ser_tx_data,
    input  logic       ser_tx_ready,
    input  logic       ser_bit_err,
    input  logic       des_valid,
    input  logic [7:0] des_data,
    input  logic       des_ferr,
    output logic       rx_data_valid,
    output logic [7:0] rx_data,
    input  logic       flag_clr,
    output logic [1:0] cmd_state,
    output logic [7:0] cur_pid,
    output logic       flag_tx_ok,
    output logic       flag_rx_ok,
    output logic [3:0] err_flags
);
    ctx_t       ctx_q, ctx_d;
    logic [7:0] pid_q;
    logic [7:0] sum_q;
    logic [7:0] seed;
    logic       idle, abort, start_tx, start_rx, tmo;
    logic       rx_live, rx_take, rx_is_data, rx_cks_good;
    logic [3:0] rx_n, rx_idx;
    logic [7:0] rx_sum;
    logic       tx_live, tx_is_data, tx_acc;
    logic [3:0] set_err;
    logic       set_tx_ok, set_rx_ok;

    assign idle     = (ctx_q.cmd == CMD_IDLE);
    assign abort    = cmd_valid && (cmd_code == CMD_IDLE);
    assign start_tx = cmd_valid && (cmd_code == CMD_TX) && idle;
    assign start_rx = cmd_valid && (cmd_code == CMD_RX) && idle;
    assign seed     = use_enhanced(ver_enh, pid_q[5:0]) ? pid_q : 8'h00;

    // receive path, merged with a command starting in this same cycle
    assign rx_live     = (ctx_q.cmd == CMD_RX) || start_rx;
    assign rx_n        = idle ? clamp_len(rx_len) : ctx_q.nbytes;
    assign rx_idx      = idle ? 4'd0 : ctx_q.idx;
    assign rx_sum      = idle ? seed : sum_q;
    assign rx_take     = rx_live && des_valid && !abort;
    assign rx_is_data  = rx_idx < rx_n;
    assign rx_cks_good = (cks_add(rx_sum, des_data) == 8'hFF);
    assign rx_data_valid = rx_take && !des_ferr && rx_is_data;
    assign rx_data       = des_data;

    // transmit path
    assign tx_live      = (ctx_q.cmd == CMD_TX);
    assign tx_is_data   = ctx_q.idx < ctx_q.nbytes;
    assign tx_acc       = tx_live && ser_tx_ready && !ser_bit_err && !abort && !tmo;
    assign tx_data_pop  = tx_acc && tx_is_data;
    assign ser_tx_valid = tx_live;
    assign ser_tx_data  = tx_is_data ? tx_data : ~sum_q;

    always_comb begin
        ctx_d     = ctx_q;
        set_err   = '0;
        set_tx_ok = 1'b0;
        set_rx_ok = 1'b0;
        if (abort) begin
            ctx_d.cmd = CMD_IDLE;
        end else begin
            if (start_tx) begin
                ctx_d = '{cmd: CMD_TX, nbytes: clamp_len(tx_len), idx: 4'd0};
            end
            if (start_rx) begin
                ctx_d = '{cmd: CMD_RX, nbytes: clamp_len(rx_len), idx: 4'd0};
            end
            if (rx_take) begin
                if (des_ferr) begin
                    set_err[E_FRM] = 1'b1;
                    ctx_d.cmd      = CMD_IDLE;
                end else if (rx_is_data) begin
                    ctx_d.idx = rx_idx + 4'd1;
                end else begin
                    set_rx_ok      = rx_cks_good;
                    set_err[E_CKS] = !rx_cks_good;
                    ctx_d.cmd      = CMD_IDLE;
                end
            end else if ((ctx_q.cmd == CMD_RX) && tmo) begin
                set_err[E_TMO] = 1'b1;
                ctx_d.cmd      = CMD_IDLE;
            end
            if (tx_live) begin
                if (ser_bit_err) begin
                    set_err[E_BIT] = 1'b1;
                    ctx_d.cmd      = CMD_IDLE;
                end else if (tmo) begin
                    set_err[E_TMO] = 1'b1;
                    ctx_d.cmd      = CMD_IDLE;
                end else if (tx_acc) begin
                    if (tx_is_data) begin
                        ctx_d.idx = ctx_q.idx + 4'd1;
                    end else begin
                        set_tx_ok = 1'b1;
                        ctx_d.cmd = CMD_IDLE;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q      <= '{cmd: CMD_IDLE, nbytes: 4'd0, idx: 4'd0};
            pid_q      <= 8'h00;
            err_flags  <= '0;
            flag_tx_ok <= 1'b0;
            flag_rx_ok <= 1'b0;
        end else begin
            ctx_q      <= ctx_d;
            if (hdr_valid) pid_q <= hdr_pid;
            err_flags  <= (flag_clr ? 4'd0 : err_flags) | set_err;
            flag_tx_ok <= (flag_clr ? 1'b0 : flag_tx_ok) | set_tx_ok;
            flag_rx_ok <= (flag_clr ? 1'b0 : flag_rx_ok) | set_rx_ok;
        end
    end

    lin_cks_acc u_cks (
        .clk      (clk),
        .rst      (rst),
        .init     (start_tx || start_rx),
        .seed     (seed),
        .add_en   (rx_data_valid || tx_data_pop),
        .add_byte (tx_live ? tx_data : des_data),
        .sum      (sum_q)
    );

    lin_frame_timer #(.SLOT_CYC(SLOT_CYC)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .start  (start_tx || start_rx),
        .run    (!idle),
        .nbytes (ctx_q.nbytes),
        .expire (tmo)
    );

    assign cmd_state = ctx_q.cmd;
    assign cur_pid   = pid_q;
endmodule

// File: rtl/lin_resp_engine_chk.sv
module lin_resp_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [1:0] cmd_code,
    input logic       hdr_valid,
    input logic [7:0] hdr_pid,
    input logic [7:0] cur_pid,
    input logic       tx_data_pop,
    input logic       ser_tx_valid,
    input logic       ser_tx_ready,
    input logic       rx_data_valid,
    input logic       flag_clr,
    input logic [1:0] cmd_state,
    input logic       flag_tx_ok,
    input logic       flag_rx_ok,
    input logic [3:0] err_flags
);
    logic [3:0] rx_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_cnt <= '0;
        end else if (cmd_state == 2'b00) begin
            rx_cnt <= rx_data_valid ? 4'd1 : 4'd0;
        end else if (rx_data_valid) begin
            rx_cnt <= rx_cnt + 4'd1;
        end
    end

    p_pop_on_accept_r1: assert property (@(posedge clk) disable iff (rst)
        tx_data_pop |-> (ser_tx_valid && ser_tx_ready));

    p_tx_done_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_tx_ok) |-> (cmd_state == 2'b00));

    p_rx_len_clamp_r2: assert property (@(posedge clk) disable iff (rst)
        rx_data_valid |-> (cmd_state == 2'b00 || rx_cnt < 4'd8));

    p_rx_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_rx_ok) |-> (cmd_state == 2'b00));

    p_err_release_r8: assert property (@(posedge clk) disable iff (rst)
        ((err_flags & ~$past(err_flags)) != 4'd0) |-> (cmd_state == 2'b00 && !ser_tx_valid));

    p_flags_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(flag_clr) |-> ((err_flags & $past(err_flags)) == $past(err_flags)));

    p_hdr_capture_r10: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |=> (cur_pid == $past(hdr_pid)));

    p_abort_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 2'b00) |=> (cmd_state == 2'b00));
endmodule

bind lin_resp_engine lin_resp_engine_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .cmd_valid     (cmd_valid),
    .cmd_code      (cmd_code),
    .hdr_valid     (hdr_valid),
    .hdr_pid       (hdr_pid),
    .cur_pid       (cur_pid),
    .tx_data_pop   (tx_data_pop),
    .ser_tx_valid  (ser_tx_valid),
    .ser_tx_ready  (ser_tx_ready),
    .rx_data_valid (rx_data_valid),
    .flag_clr      (flag_clr),
    .cmd_state     (cmd_state),
    .flag_tx_ok    (flag_tx_ok),
    .flag_rx_ok    (flag_rx_ok),
    .err_flags     (err_flags)
);

// File: tb/lin_resp_engine_tb.sv
module lin_resp_engine_tb;
    localparam int SLOT = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_code = 2'b00;
    logic       ver_enh = 1'b0;
    logic [3:0] rx_len = 4'd0;
    logic [3:0] tx_len = 4'd0;
    logic       hdr_valid = 1'b0;
    logic [7:0] hdr_pid = 8'h00;
    logic [7:0] tx_data;
    logic       tx_data_pop;
    logic       ser_tx_valid;
    logic [7:0] ser_tx_data;
    logic       ser_tx_ready = 1'b1;
    logic       ser_bit_err = 1'b0;
    logic       des_valid = 1'b0;
    logic [7:0] des_data = 8'h00;
    logic       des_ferr = 1'b0;
    logic       rx_data_valid;
    logic [7:0] rx_data;
    logic       flag_clr = 1'b0;
    logic [1:0] cmd_state;
    logic [7:0] cur_pid;
    logic       flag_tx_ok, flag_rx_ok;
    logic [3:0] err_flags;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_tx[$];
    logic [7:0] exp_rx[$];
    string      cur_req = "R1";

    logic [7:0] txq [0:63];
    logic [5:0] tx_ptr = 6'd0;
    assign tx_data = txq[tx_ptr];

    always #5 clk = ~clk;

    always @(posedge clk) if (tx_data_pop) tx_ptr <= tx_ptr + 6'd1;

    lin_resp_engine #(.SLOT_CYC(SLOT)) u_dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] add8(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[7:0] + {7'd0, s[8]};
    endfunction

    // scoreboard monitor
    always begin
        @(negedge clk);
        #1;
        if (!rst && ser_tx_valid && ser_tx_ready && !ser_bit_err) begin
            if (exp_tx.size() == 0) check({cur_req, " unexpected tx byte"}, ser_tx_data, 32'hFFFF_FFFF);
            else check({cur_req, " tx byte"}, ser_tx_data, exp_tx.pop_front());
        end
        if (!rst && rx_data_valid) begin
            if (exp_rx.size() == 0) check({cur_req, " unexpected rx byte"}, rx_data, 32'hFFFF_FFFF);
            else check({cur_req, " rx byte"}, rx_data, exp_rx.pop_front());
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic command(input logic [1:0] c);
        @(negedge clk); cmd_valid = 1'b1; cmd_code = c;
        @(negedge clk); cmd_valid = 1'b0; cmd_code = 2'b00;
    endtask

    task automatic header(input logic [7:0] p);
        @(negedge clk); hdr_valid = 1'b1; hdr_pid = p;
        @(negedge clk); hdr_valid = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic rx_byte(input logic [7:0] b, input logic fe);
        @(negedge clk); des_valid = 1'b1; des_data = b; des_ferr = fe;
        @(negedge clk); des_valid = 1'b0; des_ferr = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100; i++) begin
            #2;
            if (cmd_state == 2'b00) break;
            @(negedge clk);
        end
        cyc(1);
    endtask

    // transmit: loads queue, predicts bytes, runs the frame
    task automatic run_tx(input string req, input logic ver, input logic [7:0] pid,
                          input int len, input logic [7:0] b0);
        int n;
        logic [7:0] s;
        cur_req = req;
        n = (len > 8) ? 8 : len;
        header(pid);
        ver_enh = ver;
        tx_len  = 4'(len);
        s = (ver && pid[5:0] < 6'h3C) ? pid : 8'h00;
        for (int i = 0; i < 16; i++) txq[6'(tx_ptr + 6'(i))] = 8'(b0 + 8'(i * 37));
        for (int i = 0; i < n; i++) begin
            exp_tx.push_back(8'(b0 + 8'(i * 37)));
            s = add8(s, 8'(b0 + 8'(i * 37)));
        end
        exp_tx.push_back(~s);
        clear_flags();
        command(2'b01);
        wait_idle();
        check({req, " tx_ok"}, flag_tx_ok, 1);
        check({req, " tx queue drained"}, exp_tx.size(), 0);
    endtask

    task automatic rx_frame(input logic [7:0] pid, input logic ver, input int n,
                            input logic [7:0] b0, input logic bad);
        logic [7:0] s;
        s = (ver && pid[5:0] < 6'h3C) ? pid : 8'h00;
        for (int i = 0; i < n; i++) begin
            exp_rx.push_back(8'(b0 + 8'(i * 53)));
            s = add8(s, 8'(b0 + 8'(i * 53)));
            rx_byte(8'(b0 + 8'(i * 53)), 1'b0);
        end
        rx_byte(bad ? ~s ^ 8'h01 : ~s, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) txq[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cyc(1);
        // R11 reset state
        check("R11 reset state", cmd_state, 0);
        check("R11 reset flags", {flag_tx_ok, flag_rx_ok, err_flags}, 0);
        check("R11 reset bus", ser_tx_valid, 0);

        // R1 R3 R5 enhanced transmit, bytes with carry
        run_tx("R3", 1'b1, 8'h92, 3, 8'hE1);
        check("R1 idle after tx", cmd_state, 0);
        // R4 classic by version bit
        run_tx("R4", 1'b0, 8'h92, 2, 8'h5A);
        // R4 classic forced by identifier 0x3C
        run_tx("R4", 1'b1, 8'h3C, 2, 8'hC3);
        // R2 clamp transmit length, R5 carries
        run_tx("R2", 1'b1, 8'h11, 12, 8'hF0);
        // zero length: checksum only
        run_tx("R5", 1'b1, 8'h23, 0, 8'h00);

        // R6 good receive, enhanced
        cur_req = "R6";
        header(8'hA5); ver_enh = 1'b1; rx_len = 4'd2; clear_flags();
        command(2'b10);
        rx_frame(8'hA5, 1'b1, 2, 8'h81, 1'b0);
        cyc(1);
        check("R6 rx_ok", flag_rx_ok, 1);
        check("R6 idle", cmd_state, 0);
        check("R6 rx queue drained", exp_rx.size(), 0);

        // R2 receive clamp: 10 requested, 8 data then checksum
        cur_req = "R2";
        rx_len = 4'd10; ver_enh = 1'b0; clear_flags();
        command(2'b10);
        rx_frame(8'hA5, 1'b0, 8, 8'h3F, 1'b0);
        cyc(1);
        check("R2 rx clamp ok", flag_rx_ok, 1);
        check("R2 rx clamp idle", cmd_state, 0);

        // R7 late receive command on first byte
        cur_req = "R7";
        rx_len = 4'd2; ver_enh = 1'b1; clear_flags();
        exp_rx.push_back(8'h44);
        @(negedge clk); cmd_valid = 1'b1; cmd_code = 2'b10; des_valid = 1'b1; des_data = 8'h44;
        @(negedge clk); cmd_valid = 1'b0; cmd_code = 2'b00; des_valid = 1'b0;
        exp_rx.push_back(8'h55);
        rx_byte(8'h55, 1'b0);
        rx_byte(~add8(add8(8'hA5, 8'h44), 8'h55), 1'b0);
        cyc(1);
        check("R7 late command ok", flag_rx_ok, 1);
        check("R7 rx queue drained", exp_rx.size(), 0);

        // R6 bad checksum; flag kept for R10 below
        cur_req = "R6";
        rx_len = 4'd1; clear_flags();
        command(2'b10);
        rx_frame(8'hA5, 1'b1, 1, 8'h10, 1'b1);
        cyc(1);
        check("R6 checksum error", err_flags, 4'b0100);
        check("R6 no rx_ok", flag_rx_ok, 0);

        // R10 header during response, flags kept
        cur_req = "R10";
        rx_len = 4'd2;
        command(2'b10);
        exp_rx.push_back(8'h20);
        rx_byte(8'h20, 1'b0);
        header(8'h7F);
        check("R10 pid captured", cur_pid, 8'h7F);
        check("R10 still receiving", cmd_state, 2'b10);
        exp_rx.push_back(8'h30);
        rx_byte(8'h30, 1'b0);
        rx_byte(~add8(add8(8'hA5, 8'h20), 8'h30), 1'b0);
        cyc(1);
        check("R10 old seed ok", flag_rx_ok, 1);
        check("R10 error kept", err_flags, 4'b0100);

        // R8 framing error
        cur_req = "R8";
        clear_flags(); rx_len = 4'd3;
        command(2'b10);
        rx_byte(8'h99, 1'b1);
        check("R8 framing flag", err_flags, 4'b0010);
        check("R8 framing idle", cmd_state, 0);

        // R8 bit error in transmit
        clear_flags(); tx_len = 4'd3; ser_tx_ready = 1'b0;
        command(2'b01);
        check("R1 valid after command", ser_tx_valid, 1);
        @(negedge clk); ser_bit_err = 1'b1;
        @(negedge clk); ser_bit_err = 1'b0;
        #2;
        check("R8 bit flag", err_flags, 4'b0001);
        check("R8 bus released", {cmd_state, ser_tx_valid}, 0);
        ser_tx_ready = 1'b1;

        // R9 timeout: len 2 -> 3*SLOT cycles
        cur_req = "R9";
        clear_flags(); rx_len = 4'd2;
        command(2'b10);
        cyc(3 * SLOT - 3);
        check("R9 no early timeout", err_flags, 0);
        cyc(3);
        check("R9 timeout flag", err_flags, 4'b1000);
        check("R9 timeout idle", cmd_state, 0);

        // R11 abort and ignored command while busy
        cur_req = "R11";
        clear_flags(); rx_len = 4'd4;
        command(2'b10);
        command(2'b01);
        check("R11 busy command ignored", cmd_state, 2'b10);
        command(2'b00);
        cyc(1);
        check("R11 abort idle", cmd_state, 0);
        check("R11 abort no flags", {flag_tx_ok, flag_rx_ok, err_flags}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule